// File: doc/BRIEF.md
# Selectable-Ratio Dual Clock Divider

The block derives two clocks from one fast source clock: a processor clock and a bus clock. A 3-bit select code chooses one fixed pair of even division ratios. Each ratio is made from a prescale of 2, 3, 4 or 5 followed by a final toggle stage, which keeps both outputs at a 50% duty cycle.

Both dividers leave reset on the same source edge, so their first rising edges coincide. A one-cycle sync pulse announces each later rising edge that the two outputs share. These shared edges recur every least common multiple of the two ratios.

The select code is captured only while reset is held. Changing the code therefore requires a reset. The one unused code keeps everything quiet.

Top module: `dual_ratio_divider`

## Requirements
- R1: The select code fixes the total division of (processor, bus): 000 gives (8,8), 001 gives (6,8), 010 gives (4,6), 011 gives (6,10), 100 gives (4,8), 101 gives (6,6) and 110 gives (10,10).
- R2: Each output is high for exactly half its division ratio in source cycles and low for the other half.
- R3: While rst_ni is low, both clocks, the sync pulse and the valid flag are low. Asserting rst_ni forces this state at once, without waiting for a clock edge.
- R4: The second source rising edge after rst_ni rises drives both clocks high together.
- R5: sync_o is high for exactly the one source cycle before each rising edge shared by both outputs. Shared edges recur every least common multiple of the two ratios.
- R6: On a legal code, valid_o rises together with the first shared rising edge and stays high until reset.
- R7: With select code 111, both clocks, sync_o and valid_o stay low.
- R8: sel_i is sampled only on source edges while rst_ni is low. A change of sel_i while out of reset has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous active-low reset; the select code is captured while it is low |
| sel_i | input | 3 | Ratio-pair select code |
| pclk_o | output | 1 | Divided processor clock |
| bclk_o | output | 1 | Divided bus clock |
| sync_o | output | 1 | One-cycle pulse ahead of each shared rising edge |
| valid_o | output | 1 | Outputs are running on a legal code |

## Verification
The bench builds the block with its default counter widths: 3 bits for the prescale and 5 bits for the common-edge counter. These widths are enough for the largest prescale of 5 and the largest common period of 30. Each of the seven legal codes is run for more than two full common periods, so the 30-cycle period of code 011 and the 24-cycle period of code 001 repeat at least twice. Code 111 is run on its own. A separate run changes sel_i in mid-operation, and further runs apply reset asynchronously in mid-operation.

// File: rtl/dual_ratio_pkg.sv
`timescale 1ns/1ps
package dual_ratio_pkg;
  localparam int SEL_W = 3;
  localparam int PRE_W = 3;
  localparam int LCM_W = 5;
  localparam int N_OUT = 2;

  typedef logic [PRE_W-1:0] pre_t;
  typedef logic [LCM_W-1:0] lcm_t;

  typedef struct packed {
    pre_t pre_p;
    pre_t pre_b;
    lcm_t lcm;
  } ratio_t;

  function automatic lcm_t lcm_of(input int a, input int b);
    int x, y, t;
    x = a;
    y = b;
    for (int i = 0; i < 8; i++) begin
      if (y != 0) begin
        t = x % y;
        x = y;
        y = t;
      end
    end
    return lcm_t'((a / x) * b);
  endfunction

  // prescale values; total division is twice the prescale
  function automatic ratio_t decode(input logic [SEL_W-1:0] sel);
    ratio_t r;
    case (sel)
      3'b000:  r = '{pre_p: 3'd4, pre_b: 3'd4, lcm: lcm_of(8, 8)};
      3'b001:  r = '{pre_p: 3'd3, pre_b: 3'd4, lcm: lcm_of(6, 8)};
      3'b010:  r = '{pre_p: 3'd2, pre_b: 3'd3, lcm: lcm_of(4, 6)};
      3'b011:  r = '{pre_p: 3'd3, pre_b: 3'd5, lcm: lcm_of(6, 10)};
      3'b100:  r = '{pre_p: 3'd2, pre_b: 3'd4, lcm: lcm_of(4, 8)};
      3'b101:  r = '{pre_p: 3'd3, pre_b: 3'd3, lcm: lcm_of(6, 6)};
      3'b110:  r = '{pre_p: 3'd5, pre_b: 3'd5, lcm: lcm_of(10, 10)};
      default: r = '{pre_p: 3'd2, pre_b: 3'd2, lcm: 5'd1};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ratio_capture.sv
`timescale 1ns/1ps
module ratio_capture
  import dual_ratio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             en_o,
  output pre_t             pre_p_o,
  output pre_t             pre_b_o,
  output lcm_t             lcm_o,
  output logic             legal_o
);
  logic [SEL_W-1:0] sel_q;
  logic             run_q;
  ratio_t           r;

  // code is captured only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) sel_q <= sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  always_comb begin
    r       = decode(sel_q);
    legal_o = (sel_q != {SEL_W{1'b1}});
    en_o    = run_q && legal_o;
    pre_p_o = r.pre_p;
    pre_b_o = r.pre_b;
    lcm_o   = r.lcm;
  end

  p_sel_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(sel_q));
endmodule

// File: rtl/half_rate_div.sv
`timescale 1ns/1ps
module half_rate_div
  import dual_ratio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  pre_t pre_i,
  output logic clk_o
);
  pre_t cnt_q;
  logic clk_q;

  // count down the prescale, toggle on terminal: output period is 2*pre
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (en_i) begin
      if (cnt_q == '0) begin
        cnt_q <= pre_i - 1'b1;
        clk_q <= ~clk_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign clk_o = clk_q;

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < pre_i));
endmodule

// File: rtl/common_edge_track.sv
`timescale 1ns/1ps
module common_edge_track
  import dual_ratio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  lcm_t lcm_i,
  output logic sync_o,
  output logic valid_o
);
  lcm_t sc_q;
  logic valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_q    <= '0;
      valid_q <= 1'b0;
    end else if (en_i) begin
      valid_q <= 1'b1;
      if (sc_q == '0) sc_q <= lcm_i - 1'b1;
      else            sc_q <= sc_q - 1'b1;
    end
  end

  assign sync_o  = en_i && (sc_q == '0);
  assign valid_o = valid_q;

  p_valid_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q);
endmodule

// File: rtl/dual_ratio_divider.sv
`timescale 1ns/1ps
module dual_ratio_divider
  import dual_ratio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pclk_o,
  output logic             bclk_o,
  output logic             sync_o,
  output logic             valid_o
);
  logic en, legal;
  pre_t pre_p, pre_b;
  lcm_t lcm;
  pre_t pre_arr [N_OUT];
  logic clk_arr [N_OUT];

  ratio_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .en_o    (en),
    .pre_p_o (pre_p),
    .pre_b_o (pre_b),
    .lcm_o   (lcm),
    .legal_o (legal)
  );

  assign pre_arr[0] = pre_p;
  assign pre_arr[1] = pre_b;

  for (genvar g = 0; g < N_OUT; g++) begin : g_div
    half_rate_div u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en),
      .pre_i  (pre_arr[g]),
      .clk_o  (clk_arr[g])
    );
  end

  common_edge_track u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .lcm_i   (lcm),
    .sync_o  (sync_o),
    .valid_o (valid_o)
  );

  assign pclk_o = clk_arr[0];
  assign bclk_o = clk_arr[1];

  p_sync_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> ($rose(pclk_o) && $rose(bclk_o)));

  p_shared_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pclk_o) && $rose(bclk_o)) |-> $past(sync_o));

  p_valid_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (pclk_o && bclk_o));

  p_illegal_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal |-> (!pclk_o && !bclk_o && !sync_o && !valid_o));
endmodule

// File: tb/tb_dual_ratio_divider.sv
`timescale 1ns/1ps
module tb_dual_ratio_divider;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_i = 3'b000;
  logic       pclk_o, bclk_o, sync_o, valid_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic  pc;
    logic  bc;
    logic  sy;
    logic  va;
    string tag;
  } exp_t;

  exp_t sbq[$];
  logic mon_en = 1'b0;

  always #5 clk_i = ~clk_i;

  dual_ratio_divider dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .pclk_o  (pclk_o),
    .bclk_o  (bclk_o),
    .sync_o  (sync_o),
    .valid_o (valid_o)
  );

  // R1: total division per code
  function automatic int np_of(input logic [2:0] s);
    case (s)
      3'b000: return 8;  3'b001: return 6;  3'b010: return 4;
      3'b011: return 6;  3'b100: return 4;  3'b101: return 6;
      3'b110: return 10; default: return 0;
    endcase
  endfunction

  function automatic int nb_of(input logic [2:0] s);
    case (s)
      3'b000: return 8;  3'b001: return 8;  3'b010: return 6;
      3'b011: return 10; 3'b100: return 8;  3'b101: return 6;
      3'b110: return 10; default: return 0;
    endcase
  endfunction

  function automatic int lcm_tb(input int a, input int b);
    for (int m = 1; m <= a * b; m++)
      if ((m % a == 0) && (m % b == 0)) return m;
    return a * b;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // monitor: pops expected items, compares away from the active edge
  always @(negedge clk_i) begin
    if (mon_en && sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk({e.tag, " R1 R2"}, "pclk", pclk_o, e.pc);
      chk({e.tag, " R1 R2"}, "bclk", bclk_o, e.bc);
      chk({e.tag, " R5"}, "sync", sync_o, e.sy);
      chk({e.tag, " R6"}, "valid", valid_o, e.va);
    end
  end

  // R3: reset state, checked asynchronously mid-run and under held reset
  task automatic check_reset(input string tag);
    chk({tag, " R3"}, "pclk", pclk_o, 1'b0);
    chk({tag, " R3"}, "bclk", bclk_o, 1'b0);
    chk({tag, " R3"}, "sync", sync_o, 1'b0);
    chk({tag, " R3"}, "valid", valid_o, 1'b0);
  endtask

  task automatic run_case(input logic [2:0] s, input int cycles, input bit change_sel);
    int np, nb, l;
    bit ok;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check_reset("R3");
    sel_i = s;
    repeat (3) @(negedge clk_i);
    check_reset("R3");
    rst_ni = 1'b1;
    @(posedge clk_i);
    np = np_of(s);
    nb = nb_of(s);
    ok = (s != 3'b111);
    l  = ok ? lcm_tb(np, nb) : 1;
    for (int n = 0; n < cycles; n++) begin
      exp_t e;
      if (!ok) begin
        e = '{1'b0, 1'b0, 1'b0, 1'b0, "R7"};
      end else if (n == 0) begin
        e = '{1'b0, 1'b0, 1'b1, 1'b0, "R4"};
      end else begin
        e.pc  = (((n - 1) % np) < (np / 2));
        e.bc  = (((n - 1) % nb) < (nb / 2));
        e.sy  = ((n % l) == 0);
        e.va  = 1'b1;
        e.tag = change_sel ? "R8" : (n == 1 ? "R4" : "R1");
      end
      sbq.push_back(e);
    end
    mon_en = 1'b1;
    if (change_sel) begin
      repeat (7) @(negedge clk_i);
      sel_i = ~s;
      repeat (9) @(negedge clk_i);
      sel_i = 3'b111;
    end
    wait (sbq.size() == 0);
    @(negedge clk_i);
    mon_en = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    check_reset("R3");
    for (int s = 0; s < 7; s++) begin
      int l;
      l = lcm_tb(np_of(3'(s)), nb_of(3'(s)));
      run_case(3'(s), 2 * l + 6, 1'b0);
    end
    run_case(3'b111, 40, 1'b0);   // R7
    run_case(3'b001, 60, 1'b1);   // R8
    run_case(3'b011, 70, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check_reset("R3");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule